// File: doc/BRIEF.md
# Virtual Segment Address Decoder

This block takes a 32-bit virtual address and works out which architectural segment it falls in, and from that how it is translated to a physical address. Two kernel windows in the upper half of the space are translated directly by subtracting the window base. The mapped regions are handed to an external translation table (TLB) through a request/response pair. An access that the current privilege does not allow is answered at once with a bad-address status and never reaches the table.

Requests arrive on a valid/ready port and carry the address, a user-mode flag and an error-level flag. The fixed-mapping control pin is also sampled at acceptance. With that pin low, the block uses the table for mapped regions. With it high, the block runs a simpler fixed map in which no table is used. One translation is in flight at a time. The TLB request port is valid/ready. The TLB response has no back-pressure: it is a one-cycle pulse that the block takes only while it waits for it. The result port is valid/ready. A result is held unchanged until the consumer takes it, and no new request is accepted until that happens.

Status codes on both the TLB response and the result are: 0 match, 1 bad address, 2 no match, 3 invalid, 4 modified. The permission field uses bit 0 for read and bit 1 for write.

Top module: `vseg_xlate`

## Requirements
- R1: While reset is asserted and in the first cycle after it, req_ready is 1 and rsp_valid and tlb_req_valid are 0.
- R2: A request with req_user=1 and address bit 31 set completes with status 1, physical address 0 and permission 0, and raises no TLB request.
- R3: A request below 0x80000000 with req_erl=1 (and user access allowed) completes with status 0, the physical address equal to the virtual address, and permission 2'b11. This holds in both modes.
- R4: In table mode, a request below 0x80000000 with req_erl=0 raises tlb_req_valid with tlb_req_vaddr equal to the request address. When the response arrives with status 0, the result carries the TLB's status, physical address and permission.
- R5: A non-user request in 0x80000000..0x9FFFFFFF completes with status 0, physical address equal to the address minus 0x80000000, and permission 2'b11. This holds in both modes.
- R6: A non-user request in 0xA0000000..0xBFFFFFFF completes with status 0, physical address equal to the address minus 0xA0000000, and permission 2'b11. This holds in both modes.
- R7: In table mode, a non-user request at 0xC0000000 or above is forwarded to the TLB, as in R4.
- R8: In fixed mode, a request below 0x80000000 with req_erl=0 completes with status 0, physical address equal to the address plus 0x40000000, and permission 2'b11.
- R9: In fixed mode, a non-user request at 0xC0000000 or above completes with status 0, the address unchanged, and permission 2'b11.
- R10: A TLB response with a non-zero status is passed through as the result status, with the physical address and permission forced to 0.
- R11: Handshake rules. req_ready is 1 only when no translation is in flight. tlb_req_valid and tlb_req_vaddr hold until tlb_req_ready. A result and its fields hold until rsp_ready. A TLB response pulse is ignored unless the block is waiting for one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fixed_map | input | 1 | 1 selects fixed mapping, 0 selects table mode; sampled at request acceptance |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_user | input | 1 | Access is made in user mode |
| req_erl | input | 1 | Error level is set |
| tlb_req_valid | output | 1 | Lookup request to the TLB |
| tlb_req_ready | input | 1 | TLB accepts the lookup |
| tlb_req_vaddr | output | 32 | Address to look up |
| tlb_rsp_valid | input | 1 | One-cycle TLB response pulse |
| tlb_rsp_status | input | 3 | TLB status code |
| tlb_rsp_paddr | input | 32 | TLB physical address |
| tlb_rsp_perm | input | 2 | TLB permission (bit 0 read, bit 1 write) |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 32 | Physical address |
| rsp_perm | output | 2 | Permission (bit 0 read, bit 1 write) |
| rsp_status | output | 3 | Status code |

## Verification
The hardest case to reach is the interaction of the three handshakes around a single translation. In it, a new request is already waiting at the input while the TLB request is stalled. A response pulse arrives in a cycle when none is awaited. The result is then back-pressured for several cycles. The stimulus holds each pending request valid through the whole busy period. It toggles tlb_req_ready and rsp_ready at random, and it drives random response pulses that are legal only in the waiting state. A boundary list (segment edges at 0x7FFFFFFF, 0x80000000, 0x9FFFFFFF, 0xA0000000, 0xBFFFFFFF, 0xC0000000 and 0xFFFFFFFF) is mixed into the random addresses under every mode and flag combination.

// File: rtl/vseg_pkg.sv
package vseg_pkg;
  localparam int VA_W      = 32;
  localparam int PERM_W    = 2;
  localparam int STAT_W    = 3;
  localparam int N_WIN     = 2;
  localparam int WIN_TAG_W = 3;
  localparam logic [PERM_W-1:0] PERM_RW   = 2'b11;
  localparam logic [PERM_W-1:0] PERM_NONE = 2'b00;

  localparam logic [STAT_W-1:0] XS_MATCH    = 3'd0;
  localparam logic [STAT_W-1:0] XS_BADADDR  = 3'd1;
  localparam logic [STAT_W-1:0] XS_NOMATCH  = 3'd2;
  localparam logic [STAT_W-1:0] XS_INVALID  = 3'd3;
  localparam logic [STAT_W-1:0] XS_MODIFIED = 3'd4;

  typedef enum logic [1:0] {RT_BAD, RT_DIRECT, RT_TABLE} route_e;

  // Base of each directly translated kernel window (cached, uncached)
  function automatic logic [VA_W-1:0] win_base(input int idx);
    return (idx == 0) ? 32'h8000_0000 : 32'hA000_0000;
  endfunction
endpackage

// File: rtl/vseg_classify.sv
module vseg_classify
  import vseg_pkg::*;
#(
  parameter logic [VA_W-1:0] FIXED_OFFSET = 32'h4000_0000
) (
  input  logic [VA_W-1:0]   vaddr,
  input  logic              user,
  input  logic              erl,
  input  logic              fixed_map,
  output route_e            route,
  output logic [VA_W-1:0]   paddr,
  output logic [PERM_W-1:0] perm
);
  logic [N_WIN-1:0] win_hit;
  logic [VA_W-1:0]  win_off [N_WIN];
  logic [VA_W-1:0]  win_paddr;

  generate
    for (genvar gi = 0; gi < N_WIN; gi++) begin : g_win
      localparam logic [VA_W-1:0] BASE = win_base(gi);
      assign win_hit[gi] = (vaddr[VA_W-1 -: WIN_TAG_W] == BASE[VA_W-1 -: WIN_TAG_W]);
      assign win_off[gi] = vaddr - BASE;
    end
  endgenerate

  always_comb begin
    win_paddr = '0;
    for (int i = 0; i < N_WIN; i++) begin
      if (win_hit[i]) win_paddr = win_paddr | win_off[i];
    end
  end

  always_comb begin
    route = RT_TABLE;
    paddr = '0;
    if (user && vaddr[VA_W-1]) begin
      route = RT_BAD;
    end else if (!vaddr[VA_W-1]) begin
      if (erl) begin
        route = RT_DIRECT;
        paddr = vaddr;
      end else if (fixed_map) begin
        route = RT_DIRECT;
        paddr = vaddr + FIXED_OFFSET;
      end
    end else if (|win_hit) begin
      route = RT_DIRECT;
      paddr = win_paddr;
    end else if (fixed_map) begin
      route = RT_DIRECT;
      paddr = vaddr;
    end
    perm = (route == RT_DIRECT) ? PERM_RW : PERM_NONE;
  end
endmodule

// File: rtl/vseg_ctrl.sv
module vseg_ctrl
  import vseg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  route_e            dec_route,
  input  logic [VA_W-1:0]   dec_paddr,
  input  logic [PERM_W-1:0] dec_perm,
  output logic              tlb_req_valid,
  input  logic              tlb_req_ready,
  output logic [VA_W-1:0]   tlb_req_vaddr,
  input  logic              tlb_rsp_valid,
  input  logic [STAT_W-1:0] tlb_rsp_status,
  input  logic [VA_W-1:0]   tlb_rsp_paddr,
  input  logic [PERM_W-1:0] tlb_rsp_perm,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [VA_W-1:0]   rsp_paddr,
  output logic [PERM_W-1:0] rsp_perm,
  output logic [STAT_W-1:0] rsp_status
);
  typedef enum logic [1:0] {S_IDLE, S_TREQ, S_TWAIT, S_OUT} state_e;

  state_e            state;
  logic [VA_W-1:0]   look_va;
  logic [VA_W-1:0]   res_pa;
  logic [PERM_W-1:0] res_perm;
  logic [STAT_W-1:0] res_stat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      look_va  <= '0;
      res_pa   <= '0;
      res_perm <= PERM_NONE;
      res_stat <= XS_MATCH;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          case (dec_route)
            RT_BAD: begin
              res_stat <= XS_BADADDR;
              res_pa   <= '0;
              res_perm <= PERM_NONE;
              state    <= S_OUT;
            end
            RT_DIRECT: begin
              res_stat <= XS_MATCH;
              res_pa   <= dec_paddr;
              res_perm <= dec_perm;
              state    <= S_OUT;
            end
            default: begin
              look_va <= req_vaddr;
              state   <= S_TREQ;
            end
          endcase
        end
        S_TREQ: if (tlb_req_ready) state <= S_TWAIT;
        S_TWAIT: if (tlb_rsp_valid) begin
          res_stat <= tlb_rsp_status;
          if (tlb_rsp_status == XS_MATCH) begin
            res_pa   <= tlb_rsp_paddr;
            res_perm <= tlb_rsp_perm;
          end else begin
            res_pa   <= '0;
            res_perm <= PERM_NONE;
          end
          state <= S_OUT;
        end
        default: if (rsp_ready) state <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == S_IDLE);
  assign tlb_req_valid = (state == S_TREQ);
  assign tlb_req_vaddr = look_va;
  assign rsp_valid     = (state == S_OUT);
  assign rsp_paddr     = res_pa;
  assign rsp_perm      = res_perm;
  assign rsp_status    = res_stat;
endmodule

// File: rtl/vseg_xlate.sv
module vseg_xlate
  import vseg_pkg::*;
#(
  parameter logic [VA_W-1:0] FIXED_OFFSET = 32'h4000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fixed_map,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_user,
  input  logic              req_erl,
  output logic              tlb_req_valid,
  input  logic              tlb_req_ready,
  output logic [VA_W-1:0]   tlb_req_vaddr,
  input  logic              tlb_rsp_valid,
  input  logic [STAT_W-1:0] tlb_rsp_status,
  input  logic [VA_W-1:0]   tlb_rsp_paddr,
  input  logic [PERM_W-1:0] tlb_rsp_perm,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [VA_W-1:0]   rsp_paddr,
  output logic [PERM_W-1:0] rsp_perm,
  output logic [STAT_W-1:0] rsp_status
);
  route_e            dec_route;
  logic [VA_W-1:0]   dec_paddr;
  logic [PERM_W-1:0] dec_perm;

  vseg_classify #(.FIXED_OFFSET(FIXED_OFFSET)) u_classify (
    .vaddr     (req_vaddr),
    .user      (req_user),
    .erl       (req_erl),
    .fixed_map (fixed_map),
    .route     (dec_route),
    .paddr     (dec_paddr),
    .perm      (dec_perm)
  );

  vseg_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_vaddr      (req_vaddr),
    .dec_route      (dec_route),
    .dec_paddr      (dec_paddr),
    .dec_perm       (dec_perm),
    .tlb_req_valid  (tlb_req_valid),
    .tlb_req_ready  (tlb_req_ready),
    .tlb_req_vaddr  (tlb_req_vaddr),
    .tlb_rsp_valid  (tlb_rsp_valid),
    .tlb_rsp_status (tlb_rsp_status),
    .tlb_rsp_paddr  (tlb_rsp_paddr),
    .tlb_rsp_perm   (tlb_rsp_perm),
    .rsp_valid      (rsp_valid),
    .rsp_ready      (rsp_ready),
    .rsp_paddr      (rsp_paddr),
    .rsp_perm       (rsp_perm),
    .rsp_status     (rsp_status)
  );
endmodule

// File: rtl/vseg_xlate_chk.sv
module vseg_xlate_chk
  import vseg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [VA_W-1:0]   req_vaddr,
  input logic              req_user,
  input logic              tlb_req_valid,
  input logic              tlb_req_ready,
  input logic [VA_W-1:0]   tlb_req_vaddr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [VA_W-1:0]   rsp_paddr,
  input logic [PERM_W-1:0] rsp_perm,
  input logic [STAT_W-1:0] rsp_status
);
  logic accept;
  assign accept = req_valid && req_ready;

  assert_bad_user_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_user && req_vaddr[31]) |=>
      (rsp_valid && rsp_status == XS_BADADDR && rsp_paddr == '0 && !tlb_req_valid));

  assert_cached_win_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_user && req_vaddr[31:29] == 3'b100) |=>
      (rsp_valid && rsp_status == XS_MATCH && rsp_perm == PERM_RW &&
       rsp_paddr == {3'b000, $past(req_vaddr[28:0])}));

  assert_uncached_win_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_user && req_vaddr[31:29] == 3'b101) |=>
      (rsp_valid && rsp_status == XS_MATCH && rsp_paddr == {3'b000, $past(req_vaddr[28:0])}));

  assert_fail_zeroed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != XS_MATCH) |-> (rsp_perm == PERM_NONE && rsp_paddr == '0));

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_paddr) && $stable(rsp_perm) && $stable(rsp_status)));

  assert_lookup_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_req_valid && !tlb_req_ready) |=> (tlb_req_valid && $stable(tlb_req_vaddr)));

  assert_one_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, tlb_req_valid, rsp_valid}));
endmodule

bind vseg_xlate vseg_xlate_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_vaddr     (req_vaddr),
  .req_user      (req_user),
  .tlb_req_valid (tlb_req_valid),
  .tlb_req_ready (tlb_req_ready),
  .tlb_req_vaddr (tlb_req_vaddr),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_paddr     (rsp_paddr),
  .rsp_perm      (rsp_perm),
  .rsp_status    (rsp_status)
);

// File: tb/tb_vseg_xlate.sv
`timescale 1ns/1ps
module tb_vseg_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fixed_map = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_user = 1'b0;
  logic        req_erl = 1'b0;
  logic        tlb_req_valid;
  logic        tlb_req_ready = 1'b0;
  logic [31:0] tlb_req_vaddr;
  logic        tlb_rsp_valid = 1'b0;
  logic [2:0]  tlb_rsp_status = '0;
  logic [31:0] tlb_rsp_paddr = '0;
  logic [1:0]  tlb_rsp_perm = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_perm;
  logic [2:0]  rsp_status;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  vseg_xlate dut (.*);

  // reference model state: 0 idle, 1 lookup asked, 2 lookup waiting, 3 result held
  int          mst = 0;
  logic [31:0] m_addr, m_pa;
  logic [1:0]  m_perm;
  logic [2:0]  m_stat;
  string       m_tag = "R1";

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_accept();
    logic [31:0] a = req_vaddr;
    m_addr = a; m_perm = 2'b11; m_stat = 3'd0; mst = 3;
    if (req_user && a >= 32'h8000_0000) begin
      m_tag = "R2"; m_stat = 3'd1; m_pa = 0; m_perm = 2'b00;
    end else if (a < 32'h8000_0000) begin
      if (req_erl)        begin m_tag = "R3"; m_pa = a; end
      else if (fixed_map) begin m_tag = "R8"; m_pa = a + 32'h4000_0000; end
      else                begin m_tag = "R4"; mst = 1; end
    end else if (a < 32'hA000_0000) begin
      m_tag = "R5"; m_pa = a - 32'h8000_0000;
    end else if (a < 32'hC000_0000) begin
      m_tag = "R6"; m_pa = a - 32'hA000_0000;
    end else if (fixed_map) begin
      m_tag = "R9"; m_pa = a;
    end else begin
      m_tag = "R7"; mst = 1;
    end
  endtask

  task automatic model_step();
    case (mst)
      0: if (req_valid) model_accept();
      1: if (tlb_req_ready) mst = 2;
      2: if (tlb_rsp_valid) begin
        m_stat = tlb_rsp_status;
        if (tlb_rsp_status == 3'd0) begin m_pa = tlb_rsp_paddr; m_perm = tlb_rsp_perm; end
        else begin m_pa = 0; m_perm = 2'b00; m_tag = "R10"; end
        mst = 3;
      end
      default: if (rsp_ready) mst = 0;
    endcase
  endtask

  function automatic logic [31:0] pick_addr();
    logic [31:0] r = $urandom;
    case ($urandom % 6)
      0: return {1'b0, r[30:0]};
      1: return {3'b100, r[28:0]};
      2: return {3'b101, r[28:0]};
      3: return {2'b11, r[29:0]};
      default: case (r % 8)
        0: return 32'h0000_0000;
        1: return 32'h7FFF_FFFF;
        2: return 32'h8000_0000;
        3: return 32'h9FFF_FFFF;
        4: return 32'hA000_0000;
        5: return 32'hBFFF_FFFF;
        6: return 32'hC000_0000;
        default: return 32'hFFFF_FFFF;
      endcase
    endcase
  endfunction

  task automatic compare();
    chk(req_ready == (mst == 0), (mst == 0) ? "R11 req_ready" : "R11 busy", 32'(req_ready), 32'(mst == 0));
    chk(tlb_req_valid == (mst == 1), "R11 tlb_req_valid", 32'(tlb_req_valid), 32'(mst == 1));
    if (mst == 1) chk(tlb_req_vaddr == m_addr, m_tag, tlb_req_vaddr, m_addr);
    chk(rsp_valid == (mst == 3), "R11 rsp_valid", 32'(rsp_valid), 32'(mst == 3));
    if (mst == 3) begin
      chk(rsp_paddr == m_pa, m_tag, rsp_paddr, m_pa);
      chk(rsp_perm == m_perm, m_tag, 32'(rsp_perm), 32'(m_perm));
      chk(rsp_status == m_stat, m_tag, 32'(rsp_status), 32'(m_stat));
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) begin
      @(negedge clk);
      // R1: idle outputs while in reset
      chk(req_ready === 1'b1, "R1", 32'(req_ready), 32'd1);
      chk(rsp_valid === 1'b0, "R1", 32'(rsp_valid), 32'd0);
      chk(tlb_req_valid === 1'b0, "R1", 32'(tlb_req_valid), 32'd0);
    end
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk); compare();  // R1 first cycle after reset
    for (int cyc = 0; cyc < 6000; cyc++) begin
      @(posedge clk);
      begin
        bit took = (mst == 0) && req_valid;
        model_step();
        #1;
        if (took || !req_valid) begin
          req_valid = ($urandom % 5) != 0;
          req_vaddr = pick_addr();
          req_user  = ($urandom % 4) == 0;
          req_erl   = ($urandom % 4) == 0;
          fixed_map = ($urandom % 3) == 0;
        end
        tlb_req_ready  = $urandom % 2;
        rsp_ready      = ($urandom % 5) < 3;
        // R11: stray pulses outside the waiting state must be ignored
        tlb_rsp_valid  = (mst == 2) ? ($urandom % 2) : (($urandom % 8) == 0);
        tlb_rsp_status = (($urandom % 2) == 0) ? 3'd0 : 3'($urandom % 5);
        tlb_rsp_paddr  = $urandom;
        tlb_rsp_perm   = 2'($urandom);
      end
      @(negedge clk);
      compare();
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule